// File: doc/BRIEF.md
# Display-Priority Video RAM Arbiter

This block lets a CPU bus and a CRT display address generator share a single 2K-byte video memory. The display side always wins: while the display-enable input from the timing generator is high, the RAM address multiplexer is switched to the display address. During that time, any CPU attempt to use the video memory window is held off by pulling the CPU ready line low. When display enable is low, the CPU owns the RAM and reaches it as plain static memory.

Arbitration is coarse. The CPU is not given interleaved slots; it is frozen for the whole visible part of a scan line, which is about 40 microseconds on an 80-column display with a 15 MHz dot clock. A mode input can limit the stall to CPU writes. In that mode, reads during display time go ahead and return whatever the display address selects.

Ownership and ready are registered on the CPU clock. The multiplexer can therefore only switch on a clock edge, never in the middle of a write strobe. A CPU access that is under way in the cycle where display enable rises completes before the display takes over at the next edge.

Top module: `vram_arb`

## Requirements
- R1: While `rstN` is low, `cpuReady` is high and at every clock edge `ramMuxSel` loads the current `dispEn` level.
- R2: At every clock edge `ramMuxSel` takes the sampled `dispEn` value (1 = display owns the RAM). `ramAddr` equals `crtAddr` when `ramMuxSel` is 1 and `cpuAddr` when it is 0.
- R3: With `stallWrOnly` = 0, `cpuReady` at each edge goes low if `dispEn` is high and `vramSelN` is low, for reads and writes alike. Otherwise it goes high.
- R4: With `stallWrOnly` = 1, only a write (`cpuRnW` = 0) to the selected window during `dispEn` drives `cpuReady` low at the next edge. A read (`cpuRnW` = 1) leaves it high.
- R5: `cpuReady` is high in the cycle after any edge at which `dispEn` was sampled low, so a stall ends one edge after display enable falls.
- R6: `ramWeN` (active low) is low only when `ramMuxSel` = 0, `vramSelN` = 0, `cpuRnW` = 0 and `cpuWrStb` = 1. A deselected CPU never produces a RAM write.
- R7: `cpuDataDrv` (1 = RAM data driven toward the CPU) is 1 only when `vramSelN` = 0 and `cpuRnW` = 1. When it is 1, `cpuRdData` equals `ramRdData`; otherwise `cpuRdData` is zero.
- R8: In the cycle where `dispEn` first rises, the RAM still follows the CPU. A write in that cycle reaches `cpuAddr` with `ramWeN` low and `ramWrData` equal to `cpuWrData`. Ownership passes to the display at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Synchronous reset, active low |
| dispEn | input | 1 | Display enable from the CRT timing generator |
| stallWrOnly | input | 1 | 1 = stall only CPU writes during display time |
| vramSelN | input | 1 | Video window select from the CPU address decoder, active low |
| cpuRnW | input | 1 | CPU direction, 1 = read, 0 = write |
| cpuWrStb | input | 1 | CPU write strobe phase, active high |
| cpuAddr | input | ADDR_W | CPU address within the window |
| cpuWrData | input | DATA_W | CPU write data |
| cpuRdData | output | DATA_W | Read data returned to the CPU |
| cpuReady | output | 1 | Ready to the CPU, low = wait |
| cpuDataDrv | output | 1 | Data buffer direction, 1 = toward the CPU |
| crtAddr | input | ADDR_W | Display refresh address |
| ramAddr | output | ADDR_W | Multiplexed RAM address |
| ramMuxSel | output | 1 | Address multiplexer select, 1 = display |
| ramWeN | output | 1 | RAM write strobe, active low |
| ramWrData | output | DATA_W | Data driven into the RAM |
| ramRdData | input | DATA_W | Data read from the RAM |

## Verification
The checker watches the rules that hold on every cycle. These are the multiplexer following the display-enable level sampled at the previous edge, the address tracking the selected source, the ready response to a stall condition in both modes, ready recovering after display enable falls, and the write strobe and buffer direction never firing for a deselected or locked-out CPU. The bench scenarios cover the orderings that need a story across several cycles. These include the behaviour during reset with display enable held at either level, a write landing in the very cycle display enable rises, a long stall that ends only when display enable falls, and the contrast between read and write in write-only stall mode.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  typedef enum logic {
    OWNER_CPU  = 1'b0,
    OWNER_DISP = 1'b1
  } ramOwner_e;

  typedef struct packed {
    logic dispOwn;   // address mux points at the display
    logic ramWe;     // write strobe into RAM, active high
    logic toCpu;     // RAM read data driven toward the CPU
    logic fromCpu;   // CPU write data driven toward the RAM
  } arbStrobes_t;

endpackage

// File: rtl/vram_arb_ctrl.sv
module vram_arb_ctrl
  import vram_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dispEn,
  input  logic        stallWrOnly,
  input  logic        vramSelN,
  input  logic        cpuRnW,
  input  logic        cpuWrStb,
  output logic        cpuReady,
  output arbStrobes_t stb
);

  ramOwner_e ownerQ;
  logic      readyQ;
  logic      cpuSel;
  logic      stallKind;
  logic      stallReq;

  assign cpuSel = ~vramSelN;

  // In write-only mode a read is not a reason to wait.
  assign stallKind = stallWrOnly ? ~cpuRnW : 1'b1;
  assign stallReq  = dispEn & cpuSel & stallKind;

  // Ownership moves only on an edge, so the mux never changes
  // inside a CPU cycle. During reset it simply tracks dispEn.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerQ <= dispEn ? OWNER_DISP : OWNER_CPU;
      readyQ <= 1'b1;
    end else begin
      ownerQ <= dispEn ? OWNER_DISP : OWNER_CPU;
      readyQ <= ~stallReq;
    end
  end

  assign cpuReady = readyQ;

  always_comb begin
    stb         = '0;
    stb.dispOwn = (ownerQ == OWNER_DISP);
    stb.toCpu   = cpuSel & cpuRnW;
    if (ownerQ == OWNER_CPU) begin
      stb.fromCpu = cpuSel & ~cpuRnW;
      stb.ramWe   = cpuSel & ~cpuRnW & cpuWrStb;
    end
  end

endmodule

// File: rtl/vram_arb_dpath.sv
module vram_arb_dpath
  import vram_arb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  arbStrobes_t       stb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] crtAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic [DATA_W-1:0] cpuRdData
);

  always_comb begin
    ramAddr = stb.dispOwn ? crtAddr : cpuAddr;
  end

  // Per-bit buffer gating, like a row of tri-state drivers folded to logic.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bufBit
    assign ramWrData[b] = cpuWrData[b] & stb.fromCpu;
    assign cpuRdData[b] = ramRdData[b] & stb.toCpu;
  end

endmodule

// File: rtl/vram_arb.sv
module vram_arb
  import vram_arb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispEn,
  input  logic              stallWrOnly,
  input  logic              vramSelN,
  input  logic              cpuRnW,
  input  logic              cpuWrStb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuReady,
  output logic              cpuDataDrv,
  input  logic [ADDR_W-1:0] crtAddr,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramMuxSel,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData
);

  arbStrobes_t stb;

  vram_arb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dispEn     (dispEn),
    .stallWrOnly(stallWrOnly),
    .vramSelN   (vramSelN),
    .cpuRnW     (cpuRnW),
    .cpuWrStb   (cpuWrStb),
    .cpuReady   (cpuReady),
    .stb        (stb)
  );

  vram_arb_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .stb      (stb),
    .cpuAddr  (cpuAddr),
    .crtAddr  (crtAddr),
    .cpuWrData(cpuWrData),
    .ramRdData(ramRdData),
    .ramAddr  (ramAddr),
    .ramWrData(ramWrData),
    .cpuRdData(cpuRdData)
  );

  assign ramMuxSel  = stb.dispOwn;
  assign ramWeN     = ~stb.ramWe;
  assign cpuDataDrv = stb.toCpu;

endmodule

// File: rtl/vram_arb_chk.sv
module vram_arb_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              dispEn,
  input logic              stallWrOnly,
  input logic              vramSelN,
  input logic              cpuRnW,
  input logic              cpuWrStb,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [ADDR_W-1:0] crtAddr,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramMuxSel,
  input logic              ramWeN,
  input logic              cpuReady,
  input logic              cpuDataDrv,
  input logic [DATA_W-1:0] cpuRdData,
  input logic [DATA_W-1:0] ramRdData
);

  AST_MUX_TRACKS_DEN: assert property (@(posedge clk) disable iff (!rstN)
    ramMuxSel == $past(dispEn)); // R2

  AST_ADDR_DISP: assert property (@(posedge clk) disable iff (!rstN)
    ramMuxSel |-> ramAddr == crtAddr); // R2

  AST_ADDR_CPU: assert property (@(posedge clk) disable iff (!rstN)
    !ramMuxSel |-> ramAddr == cpuAddr); // R2

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (!stallWrOnly && dispEn && !vramSelN) |=> !cpuReady); // R3

  AST_WRONLY_READ_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (stallWrOnly && cpuRnW && dispEn && !vramSelN) |=> cpuReady); // R4

  AST_WRONLY_WRITE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (stallWrOnly && !cpuRnW && dispEn && !vramSelN) |=> !cpuReady); // R4

  AST_READY_RECOVERS: assert property (@(posedge clk) disable iff (!rstN)
    !dispEn |=> cpuReady); // R5

  AST_WE_CPU_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> (!ramMuxSel && !vramSelN && !cpuRnW && cpuWrStb)); // R6

  AST_DRV_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    cpuDataDrv |-> (!vramSelN && cpuRnW)); // R7

  AST_RDDATA_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cpuDataDrv |-> cpuRdData == '0); // R7

endmodule

bind vram_arb vram_arb_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dispEn     (dispEn),
  .stallWrOnly(stallWrOnly),
  .vramSelN   (vramSelN),
  .cpuRnW     (cpuRnW),
  .cpuWrStb   (cpuWrStb),
  .cpuAddr    (cpuAddr),
  .crtAddr    (crtAddr),
  .ramAddr    (ramAddr),
  .ramMuxSel  (ramMuxSel),
  .ramWeN     (ramWeN),
  .cpuReady   (cpuReady),
  .cpuDataDrv (cpuDataDrv),
  .cpuRdData  (cpuRdData),
  .ramRdData  (ramRdData)
);

// File: tb/vram_arb_bench.sv
`timescale 1ns/1ps
module vram_arb_bench;

  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          dispEn, stallWrOnly, vramSelN, cpuRnW, cpuWrStb;
  logic [AW-1:0] cpuAddr, crtAddr, ramAddr;
  logic [DW-1:0] cpuWrData, cpuRdData, ramWrData, ramRdData;
  logic          cpuReady, cpuDataDrv, ramMuxSel, ramWeN;

  int nCmp = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  vram_arb u_vram_arb (
    .clk(clk), .rstN(rstN), .dispEn(dispEn), .stallWrOnly(stallWrOnly),
    .vramSelN(vramSelN), .cpuRnW(cpuRnW), .cpuWrStb(cpuWrStb),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .cpuReady(cpuReady), .cpuDataDrv(cpuDataDrv), .crtAddr(crtAddr),
    .ramAddr(ramAddr), .ramMuxSel(ramMuxSel), .ramWeN(ramWeN),
    .ramWrData(ramWrData), .ramRdData(ramRdData)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Advance one edge; land 1 ns after it.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idleCpu();
    vramSelN = 1'b1; cpuRnW = 1'b1; cpuWrStb = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0; dispEn = 1'b1; stallWrOnly = 1'b0; idleCpu();
    cpuAddr = 11'h123; crtAddr = 11'h456; cpuWrData = 8'hA5; ramRdData = 8'h3C;
    // stall request present during reset must not drop ready
    vramSelN = 1'b0;
    step(); step();
    chk("R1", "ready in reset", cpuReady, 1);
    chk("R1", "mux follows dispEn=1 in reset", ramMuxSel, 1);
    dispEn = 1'b0;
    step();
    chk("R1", "mux follows dispEn=0 in reset", ramMuxSel, 0);
    idleCpu();
    rstN = 1'b1;
    step();
    chk("R1", "ready after release", cpuReady, 1);
  endtask

  task automatic tRiseWrite();
    stallWrOnly = 1'b0;
    dispEn = 1'b1;
    vramSelN = 1'b0; cpuRnW = 1'b0; cpuWrStb = 1'b1;
    cpuAddr = 11'h2AB; crtAddr = 11'h7F0; cpuWrData = 8'h5A;
    #1;
    chk("R8", "addr on rise cycle", ramAddr, 11'h2AB);
    chk("R8", "write strobe on rise cycle", ramWeN, 0);
    chk("R8", "write data on rise cycle", ramWrData, 8'h5A);
    step();
    chk("R2", "mux to display", ramMuxSel, 1);
    chk("R2", "display address", ramAddr, 11'h7F0);
    chk("R6", "no write while display owns", ramWeN, 1);
    chk("R3", "write stalled", cpuReady, 0);
    idleCpu(); dispEn = 1'b0;
    step();
    chk("R5", "ready back", cpuReady, 1);
    chk("R2", "mux back to cpu", ramMuxSel, 0);
  endtask

  task automatic tLongStall();
    stallWrOnly = 1'b0;
    dispEn = 1'b1; vramSelN = 1'b0; cpuRnW = 1'b1; cpuAddr = 11'h010;
    step();
    chk("R3", "read stalled", cpuReady, 0);
    for (int i = 0; i < 20; i++) step();
    chk("R3", "still stalled after 21 edges", cpuReady, 0);
    dispEn = 1'b0;
    #1;
    chk("R5", "ready still low before edge", cpuReady, 0);
    step();
    chk("R5", "ready high one edge after fall", cpuReady, 1);
    chk("R2", "cpu address again", ramAddr, 11'h010);
    idleCpu();
  endtask

  task automatic tWriteOnly();
    stallWrOnly = 1'b1;
    dispEn = 1'b1; vramSelN = 1'b0; cpuRnW = 1'b1;
    step();
    chk("R4", "read not stalled", cpuReady, 1);
    chk("R4", "read drives cpu bus", cpuDataDrv, 1);
    cpuRnW = 1'b0; cpuWrStb = 1'b1;
    step();
    chk("R4", "write stalled", cpuReady, 0);
    chk("R6", "held write blocked", ramWeN, 1);
    idleCpu();
    step();
    chk("R3", "deselected not stalled", cpuReady, 1);
    dispEn = 1'b0; stallWrOnly = 1'b0;
    step();
  endtask

  task automatic tIdleAndAccess();
    dispEn = 1'b0;
    vramSelN = 1'b1; cpuRnW = 1'b0; cpuWrStb = 1'b1; ramRdData = 8'hC3;
    step();
    chk("R6", "deselected no write", ramWeN, 1);
    chk("R7", "deselected no drive", cpuDataDrv, 0);
    chk("R7", "deselected read data zero", cpuRdData, 0);
    vramSelN = 1'b0; cpuRnW = 1'b1; cpuWrStb = 1'b0;
    #1;
    chk("R7", "read drives", cpuDataDrv, 1);
    chk("R7", "read data passes", cpuRdData, 8'hC3);
    chk("R6", "read no write", ramWeN, 1);
    cpuRnW = 1'b0; cpuWrStb = 1'b0;
    #1;
    chk("R6", "write before strobe", ramWeN, 1);
    chk("R7", "write does not drive cpu", cpuDataDrv, 0);
    cpuWrStb = 1'b1; cpuWrData = 8'h96;
    #1;
    chk("R6", "write strobe", ramWeN, 0);
    chk("R8", "write data", ramWrData, 8'h96);
    idleCpu();
  endtask

  initial begin
    fork
      begin
        tReset();
        tRiseWrite();
        tLongStall();
        tWriteOnly();
        tIdleAndAccess();
      end
      begin
        repeat (5000) @(posedge clk);
        nCmp++; nBad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule